// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two bidirectional data buses, called A and B, through a pair of independent storage latches. One latch takes data from the A bus and can drive it onto the B bus. The other takes data from the B bus and can drive it onto the A bus. Each direction has three active-low controls:

- a chip enable,
- a load enable,
- a drive enable.

The chip enable gates both loading and driving for its direction. Loading and driving can therefore be sequenced on their own, as long as the chip enable is low.

The block is synchronous to `clk`. While a direction is open for loading, its latch takes the source bus value at every rising clock edge. That value appears on the far port one clock later. When loading closes, the latch keeps the last value it took. A port that is not driven is left at high impedance, so that other agents on the bus can drive it. An asynchronous active-low reset clears both latches to zero so that simulation starts from known contents.

Top module: `bilatch_xcvr`

## Requirements
- R1: While `rst_n` is low, both latches are zero. The first value driven on either port after reset is 0x00.
- R2: The A-to-B latch loads when `ab_ce_n` and `ab_le_n` are both low at a rising clock edge. It takes the A bus value from that edge, and that value is seen on B one clock later if B is driven.
- R3: With `ab_ce_n` low and `ab_le_n` high, the A-to-B latch keeps the last value it loaded, whatever the A bus does.
- R4: With `ab_ce_n` high, the A-to-B latch keeps its value, whatever `ab_le_n` and the A bus do.
- R5: The B port carries the A-to-B latch value only while `ab_ce_n` and `ab_oe_n` are both low. Otherwise the block releases B to high impedance.
- R6: The B-to-A direction works the same way from B to A, using `ba_ce_n`, `ba_le_n` and `ba_oe_n`.
- R7: The controls of one direction have no effect on the stored value or the port drive of the other direction.
- R8: When both directions drive at once, A carries the B-to-A latch and B carries the A-to-B latch. If both also load, each latch takes the other latch's previous value, so the two values swap at every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; latches load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of both latches |
| a_io | inout | W | A bus; source of A-to-B data, driven from the B-to-A latch |
| b_io | inout | W | B bus; source of B-to-A data, driven from the A-to-B latch |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B load enable, active low |
| ab_oe_n | input | 1 | A-to-B drive enable for B, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A load enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable for A, active low |

## Verification
A latch that loads when it should hold shows up on the far port one clock after the source bus changes. A latch that misses a load shows a stale value at that same point. A drive enable that is wrongly decoded shows up at once, within the same cycle: either the bus pull-up level appears where latch data is expected, or latch data appears where the bus should be released. Cross-coupling between the two directions is exposed by the swap pattern. Under that pattern every edge must exchange the two values, so a single wrong edge breaks the alternation on the next cycle.

// File: rtl/bilatch_pkg.sv
package bilatch_pkg;

  // A direction loads at a clock edge when both its chip and load enables are low
  function automatic logic load_open(input logic ce_n, input logic le_n);
    return (~ce_n) & (~le_n);
  endfunction

  // A direction drives its far port when both its chip and drive enables are low
  function automatic logic drive_open(input logic ce_n, input logic oe_n);
    return (~ce_n) & (~oe_n);
  endfunction

endpackage

// File: rtl/bilatch_dir.sv
module bilatch_dir
  import bilatch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         le_n,
  input  logic         oe_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] q_o,
  output logic         load_o,
  output logic         drive_o
);

  logic [W-1:0] store_q;

  // Named events for the assertions and the top level
  assign load_o  = load_open(ce_n, le_n);
  assign drive_o = drive_open(ce_n, oe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (load_o) begin
      store_q <= src_i;
    end
  end

  assign q_o = store_q;

  AST_LOAD_TAKES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (q_o == $past(src_i)));  // R2

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |=> $stable(q_o));  // R3

  AST_CHIP_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> $stable(q_o));  // R4

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_o == '0));  // R1

endmodule

// File: rtl/bilatch_xcvr.sv
module bilatch_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         ab_ce_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_ce_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n
);

  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;
  logic         ab_load;
  logic         ab_drive;
  logic         ba_load;
  logic         ba_drive;

  // A to B: sourced from the A bus, drives the B bus
  bilatch_dir #(.W(W)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ab_ce_n),
    .le_n    (ab_le_n),
    .oe_n    (ab_oe_n),
    .src_i   (a_io),
    .q_o     (ab_q),
    .load_o  (ab_load),
    .drive_o (ab_drive)
  );

  // B to A: sourced from the B bus, drives the A bus
  bilatch_dir #(.W(W)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ba_ce_n),
    .le_n    (ba_le_n),
    .oe_n    (ba_oe_n),
    .src_i   (b_io),
    .q_o     (ba_q),
    .load_o  (ba_load),
    .drive_o (ba_drive)
  );

  // Tri-state port drivers, released whenever the direction is not driving
  assign b_io = ab_drive ? ab_q : {W{1'bz}};
  assign a_io = ba_drive ? ba_q : {W{1'bz}};

  // When A is driven by the block, an A-to-B load takes the other latch's value
  AST_AB_TAKES_BA: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_load && ba_drive) |=> (ab_q == $past(ba_q)));  // R8

  AST_BA_TAKES_AB: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_load && ab_drive) |=> (ba_q == $past(ab_q)));  // R8

  // A direction that is closed keeps its value whatever the other side does
  AST_AB_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_ce_n && ba_load) |=> $stable(ab_q));  // R7

endmodule

// File: tb/bilatch_xcvr_tb_top.sv
module bilatch_xcvr_tb_top;

  localparam int W = 8;
  localparam logic [W-1:0] REL = {W{1'b1}};  // pull-up level of a released bus

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ab_ce_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_ce_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
  logic         a_en = 1'b0, b_en = 1'b0;
  logic [W-1:0] a_drv = '0, b_drv = '0;

  tri1 [W-1:0] a_bus;
  tri1 [W-1:0] b_bus;

  assign a_bus = a_en ? a_drv : {W{1'bz}};
  assign b_bus = b_en ? b_drv : {W{1'bz}};

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bilatch_xcvr #(.W(W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_io    (a_bus),
    .b_io    (b_bus),
    .ab_ce_n (ab_ce_n),
    .ab_le_n (ab_le_n),
    .ab_oe_n (ab_oe_n),
    .ba_ce_n (ba_ce_n),
    .ba_le_n (ba_le_n),
    .ba_oe_n (ba_oe_n)
  );

  // Advance one rising edge and land 1 ns after it, away from the edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    ab_le_n = 1'b1; ba_le_n = 1'b1;
    ab_ce_n = 1'b0; ab_oe_n = 1'b0;
    ba_ce_n = 1'b0; ba_oe_n = 1'b0;
    #1;
    check("R1 B after reset", b_bus, 8'h00);
    check("R1 A after reset", a_bus, 8'h00);
    ab_ce_n = 1'b1; ab_oe_n = 1'b1;
    ba_ce_n = 1'b1; ba_oe_n = 1'b1;
    #1;
    check("R5 B released", b_bus, REL);
  endtask

  task automatic t_ab_load();
    a_en = 1'b1; a_drv = 8'h5A;
    ab_ce_n = 1'b0; ab_le_n = 1'b0; ab_oe_n = 1'b0;
    step();
    check("R2 first load", b_bus, 8'h5A);
    a_drv = 8'hC3;
    #1;
    check("R2 no change before edge", b_bus, 8'h5A);
    step();
    check("R2 follows A", b_bus, 8'hC3);
  endtask

  task automatic t_ab_hold_le();
    ab_le_n = 1'b1;
    a_drv = 8'h11;
    step(2);
    check("R3 hold after load enable rise", b_bus, 8'hC3);
  endtask

  task automatic t_ab_hold_ce();
    ab_ce_n = 1'b1; ab_le_n = 1'b0;
    a_drv = 8'h22;
    step(2);
    check("R5 B released with chip enable high", b_bus, REL);
    ab_ce_n = 1'b0; ab_le_n = 1'b1;
    #1;
    check("R4 hold while chip enable high", b_bus, 8'hC3);
  endtask

  task automatic t_ab_oe();
    ab_oe_n = 1'b1;
    #1;
    check("R5 B released with drive enable high", b_bus, REL);
    step();
    ab_oe_n = 1'b0;
    #1;
    check("R5 B driven again", b_bus, 8'hC3);
  endtask

  task automatic t_ba_dir();
    ab_oe_n = 1'b1; a_en = 1'b0;
    b_en = 1'b1; b_drv = 8'h96;
    ba_ce_n = 1'b0; ba_le_n = 1'b0; ba_oe_n = 1'b0;
    step();
    check("R6 B-to-A load", a_bus, 8'h96);
    ba_le_n = 1'b1; b_drv = 8'h44;
    step();
    check("R6 B-to-A hold", a_bus, 8'h96);
    ba_oe_n = 1'b1;
    #1;
    check("R6 A released", a_bus, REL);
  endtask

  task automatic t_indep();
    // A-to-B holds C3 and does not drive B; B-to-A loads from the external B bus
    ab_ce_n = 1'b1; ab_le_n = 1'b0;
    b_drv = 8'h3C; ba_le_n = 1'b0;
    step();
    ba_le_n = 1'b1; b_en = 1'b0;
    ab_ce_n = 1'b0; ab_le_n = 1'b1; ab_oe_n = 1'b0;
    step();
    check("R7 A-to-B unaffected by B-to-A load", b_bus, 8'hC3);
    ba_oe_n = 1'b0;
    #1;
    check("R7 B-to-A took 3C", a_bus, 8'h3C);
    ab_ce_n = 1'b1; ab_le_n = 1'b0;
    step();
    check("R7 A unaffected by A-to-B controls", a_bus, 8'h3C);
    ab_ce_n = 1'b0; ab_le_n = 1'b1;
    #1;
  endtask

  task automatic t_contention();
    // Both latches hold; each port carries its own latch
    check("R8 A from B-to-A latch", a_bus, 8'h3C);
    check("R8 B from A-to-B latch", b_bus, 8'hC3);
    ab_le_n = 1'b0; ba_le_n = 1'b0;
    step();
    check("R8 swap A", a_bus, 8'hC3);
    check("R8 swap B", b_bus, 8'h3C);
    step();
    check("R8 swap back A", a_bus, 8'h3C);
    check("R8 swap back B", b_bus, 8'hC3);
    ab_le_n = 1'b1; ba_le_n = 1'b1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_ab_load();
    t_ab_hold_le();
    t_ab_hold_ce();
    t_ab_oe();
    t_ba_dir();
    t_indep();
    t_contention();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule